// File: doc/BRIEF.md
# Event Log Interrupt Policy Controller

This block keeps the interrupt policy of a memory device's five event logs: informational, warning, failure, fatal and dynamic capacity. A command port serves two operations. A read operation returns one policy byte per log. A write operation sets the per-log interrupt enables from a byte payload of a given length. Each command returns a status, a response length and, for a read, the policy bytes. The response comes back one cycle after the command.

Each log has a fixed message vector. The first four logs take consecutive vectors from a start parameter. The dynamic capacity log shares the informational log's vector. When a notify request arrives, the block takes a snapshot of the logs that are both enabled and non-empty. It then sends one vector notification per log, lowest log index first, over a valid/ready output. Each notification is tagged as MSI-X when that signalling path is enabled, and as MSI when only MSI is enabled. When neither path is enabled, nothing is sent.

Top module: `evt_irq_policy_ctrl`

## Requirements
- R1: After reset every log is disabled, irq_valid_o and rsp_done_o are low, and a read returns five zero bytes.
- R2: On a write, a log is enabled only when bits [1:0] of its byte equal 1 (MSI/MSI-X mode). The values 0 (none), 2 (firmware) and 3 (reserved) disable the log, and bits [7:2] of the written byte are ignored.
- R3: A read (cmd_op_i = 0) returns status 0 and length 5. Payload byte k is at bits [8k+7:8k], with k = 0 informational, 1 warning, 2 failure, 3 fatal and 4 dynamic capacity. For an enabled log among the first four, the byte is {vector[3:0], 2'b00, 2'b01}. For a disabled log the byte is 0.
- R4: A read reports an enabled dynamic capacity log as 8'h01, with its vector nibble at zero.
- R5: A write (cmd_op_i = 1) with length below 4 returns status 1 (invalid payload length), length 0 and a zero payload, and changes no enable.
- R6: A write of length 4 updates only the first four logs, keeps the dynamic capacity enable, and returns status 0 and length 4. A write of length 5 or more also updates the dynamic capacity log and returns length 5.
- R7: Log k (k < 4) uses vector START_VEC+k (2, 3, 4, 5 by default). The dynamic capacity log uses the informational vector.
- R8: After a notify request, each log that is enabled and non-empty produces exactly one notification, in ascending log order. Each notification takes one cycle in which both irq_valid_o and irq_ready_i are high. While irq_ready_i is low, irq_vec_o and irq_msix_o hold.
- R9: irq_msix_o is 1 when msix_en_i was high at the notify request. It is 0 when only msi_en_i was high. When both were low, no notification is sent.
- R10: rsp_done_o is high for exactly the cycle after each cycle in which cmd_valid_i is high.
- R11: A notify request that arrives while notifications are still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 1 | 0 read policy, 1 write policy |
| cmd_len_i | input | LEN_W | Write payload length in bytes |
| cmd_payload_i | input | 40 | Write payload, byte k at [8k+7:8k] |
| rsp_done_o | output | 1 | Response valid pulse |
| rsp_status_o | output | 2 | 0 success, 1 invalid payload length |
| rsp_len_o | output | LEN_W | Response length |
| rsp_payload_o | output | 40 | Read payload |
| notify_i | input | 1 | Start a notification scan |
| log_nonempty_i | input | 5 | Per-log non-empty flags |
| msix_en_i | input | 1 | MSI-X signalling enabled |
| msi_en_i | input | 1 | MSI signalling enabled |
| irq_valid_o | output | 1 | Notification pending |
| irq_ready_i | input | 1 | Notification accepted |
| irq_vec_o | output | VEC_W | Vector of the current notification |
| irq_msix_o | output | 1 | 1 MSI-X, 0 MSI |

## Verification
The hardest state to reach is a notify request that lands while an earlier scan still has pending entries. The snapshot would otherwise absorb it silently. The bench holds irq_ready_i low after starting a scan on two logs, then pulses notify_i with a disjoint set of non-empty logs. On release it expects only the first scan's vectors, in order. The same stall window checks that the presented vector holds. Another write of length 4 after the dynamic capacity log is enabled shows that the fifth enable survives.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NLOG        = 5;
  localparam int LOG_INFO    = 0;
  localparam int LOG_DC      = 4;
  localparam int MIN_SET_LEN = 4;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_INT  = 2'd1,
    MODE_FW   = 2'd2,
    MODE_RSV  = 2'd3
  } irq_mode_e;

  typedef enum logic [1:0] {
    STS_OK      = 2'd0,
    STS_BAD_LEN = 2'd1
  } cmd_status_e;

  typedef enum logic {
    OP_GET = 1'b0,
    OP_SET = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/evt_policy_regs.sv
module evt_policy_regs
  import evt_irq_pkg::*;
#(
  parameter int VEC_W     = 4,
  parameter int START_VEC = 2,
  parameter int LEN_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_op_i,
  input  logic [LEN_W-1:0]      cmd_len_i,
  input  logic [8*NLOG-1:0]     cmd_payload_i,
  output logic [NLOG-1:0]       en_o,
  output logic [NLOG*VEC_W-1:0] vec_o,
  output logic                  rsp_done_o,
  output logic [1:0]            rsp_status_o,
  output logic [LEN_W-1:0]      rsp_len_o,
  output logic [8*NLOG-1:0]     rsp_payload_o
);
  localparam int PL_W = 8*NLOG;

  logic [NLOG-1:0]  en_q, en_nx, req_en, unused_hi;
  logic [PL_W-1:0]  get_pl, pl_nx;
  logic [LEN_W-1:0] len_nx;
  cmd_status_e      sts_nx;

  for (genvar i = 0; i < NLOG; i++) begin : g_log
    localparam int VI = (i == LOG_DC) ? START_VEC + LOG_INFO : START_VEC + i;
    assign vec_o[i*VEC_W +: VEC_W] = VEC_W'(VI);
    assign req_en[i]    = (cmd_payload_i[8*i +: 2] == MODE_INT);
    assign unused_hi[i] = ^cmd_payload_i[8*i+2 +: 6];
    if (i == LOG_DC) begin : g_dc
      // shared vector is not reported for this log
      assign get_pl[8*i +: 8] = en_q[i] ? {6'b0, MODE_INT} : 8'h00;
    end else begin : g_std
      assign get_pl[8*i +: 8] = en_q[i] ? {4'(VI), 2'b00, MODE_INT} : 8'h00;
    end
  end

  always_comb begin
    en_nx  = en_q;
    sts_nx = STS_OK;
    len_nx = '0;
    pl_nx  = '0;
    if (cmd_op_i == OP_SET) begin
      if (cmd_len_i < LEN_W'(MIN_SET_LEN)) begin
        sts_nx = STS_BAD_LEN;
      end else begin
        en_nx[LOG_DC-1:0] = req_en[LOG_DC-1:0];
        if (cmd_len_i >= LEN_W'(NLOG)) begin
          en_nx[LOG_DC] = req_en[LOG_DC];
          len_nx        = LEN_W'(NLOG);
        end else begin
          len_nx = cmd_len_i;
        end
      end
    end else begin
      pl_nx  = get_pl;
      len_nx = LEN_W'(NLOG);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q          <= '0;
      rsp_done_o    <= 1'b0;
      rsp_status_o  <= STS_OK;
      rsp_len_o     <= '0;
      rsp_payload_o <= '0;
    end else begin
      rsp_done_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        en_q          <= en_nx;
        rsp_status_o  <= sts_nx;
        rsp_len_o     <= len_nx;
        rsp_payload_o <= pl_nx;
      end
    end
  end

  assign en_o = en_q;

  AST_BADLEN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SET && cmd_len_i < LEN_W'(MIN_SET_LEN))
      |=> ($stable(en_q) && rsp_status_o == STS_BAD_LEN)); // R5
  AST_DC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SET && cmd_len_i == LEN_W'(MIN_SET_LEN))
      |=> (en_q[LOG_DC] == $past(en_q[LOG_DC]))); // R6
  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_done_o); // R10
  AST_DONE_ONLY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_done_o); // R10
  AST_GET_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_GET)
      |=> (rsp_len_o == LEN_W'(NLOG) && rsp_status_o == STS_OK)); // R3
endmodule

// File: rtl/evt_notify_scan.sv
module evt_notify_scan
  import evt_irq_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  notify_i,
  input  logic [NLOG-1:0]       nonempty_i,
  input  logic [NLOG-1:0]       en_i,
  input  logic [NLOG*VEC_W-1:0] vec_i,
  input  logic                  msix_en_i,
  input  logic                  msi_en_i,
  output logic                  irq_valid_o,
  input  logic                  irq_ready_i,
  output logic [VEC_W-1:0]      irq_vec_o,
  output logic                  irq_msix_o
);
  logic [NLOG-1:0] pend_q, sel_oh;
  logic            msix_q, busy, fire;

  assign busy   = |pend_q;
  assign sel_oh = pend_q & (~pend_q + NLOG'(1)); // lowest index wins
  assign fire   = irq_valid_o && irq_ready_i;

  always_comb begin
    irq_vec_o = '0;
    for (int i = 0; i < NLOG; i++) begin
      if (sel_oh[i]) irq_vec_o = irq_vec_o | vec_i[i*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      msix_q <= 1'b0;
    end else if (!busy && notify_i) begin
      pend_q <= (msix_en_i || msi_en_i) ? (en_i & nonempty_i) : '0;
      msix_q <= msix_en_i;
    end else if (fire) begin
      pend_q <= pend_q & ~sel_oh;
    end
  end

  assign irq_valid_o = busy;
  assign irq_msix_o  = msix_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !irq_ready_i)
      |=> (irq_valid_o && $stable(irq_vec_o) && $stable(irq_msix_o))); // R8
  AST_ONE_PER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R8
  AST_NO_PATH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_i && !busy && !msix_en_i && !msi_en_i) |=> !irq_valid_o); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && notify_i && !fire) |=> $stable(pend_q)); // R11
endmodule

// File: rtl/evt_irq_policy_ctrl.sv
module evt_irq_policy_ctrl
  import evt_irq_pkg::*;
#(
  parameter int VEC_W     = 4,
  parameter int START_VEC = 2,
  parameter int LEN_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_op_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [39:0]       cmd_payload_i,
  output logic              rsp_done_o,
  output logic [1:0]        rsp_status_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic [39:0]       rsp_payload_o,
  input  logic              notify_i,
  input  logic [4:0]        log_nonempty_i,
  input  logic              msix_en_i,
  input  logic              msi_en_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_msix_o
);
  logic [NLOG-1:0]       en;
  logic [NLOG*VEC_W-1:0] vec;

  evt_policy_regs #(
    .VEC_W(VEC_W), .START_VEC(START_VEC), .LEN_W(LEN_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_len_i    (cmd_len_i),
    .cmd_payload_i(cmd_payload_i),
    .en_o         (en),
    .vec_o        (vec),
    .rsp_done_o   (rsp_done_o),
    .rsp_status_o (rsp_status_o),
    .rsp_len_o    (rsp_len_o),
    .rsp_payload_o(rsp_payload_o)
  );

  evt_notify_scan #(.VEC_W(VEC_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .notify_i   (notify_i),
    .nonempty_i (log_nonempty_i),
    .en_i       (en),
    .vec_i      (vec),
    .msix_en_i  (msix_en_i),
    .msi_en_i   (msi_en_i),
    .irq_valid_o(irq_valid_o),
    .irq_ready_i(irq_ready_i),
    .irq_vec_o  (irq_vec_o),
    .irq_msix_o (irq_msix_o)
  );
endmodule

// File: tb/tb_evt_irq_policy_ctrl.sv
module tb_evt_irq_policy_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cmd_valid_i = 0, cmd_op_i = 0;
  logic [3:0]  cmd_len_i = '0;
  logic [39:0] cmd_payload_i = '0;
  logic        rsp_done_o;
  logic [1:0]  rsp_status_o;
  logic [3:0]  rsp_len_o;
  logic [39:0] rsp_payload_o;
  logic        notify_i = 0, msix_en_i = 0, msi_en_i = 0, irq_ready_i = 1;
  logic [4:0]  log_nonempty_i = '0;
  logic        irq_valid_o, irq_msix_o;
  logic [3:0]  irq_vec_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [4:0]  model_en = '0;
  logic [45:0] rsp_q[$];
  logic [4:0]  irq_q[$];

  always #5 clk = ~clk;

  evt_irq_policy_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_len_i(cmd_len_i), .cmd_payload_i(cmd_payload_i), .rsp_done_o(rsp_done_o),
    .rsp_status_o(rsp_status_o), .rsp_len_o(rsp_len_o), .rsp_payload_o(rsp_payload_o),
    .notify_i(notify_i), .log_nonempty_i(log_nonempty_i), .msix_en_i(msix_en_i),
    .msi_en_i(msi_en_i), .irq_valid_o(irq_valid_o), .irq_ready_i(irq_ready_i),
    .irq_vec_o(irq_vec_o), .irq_msix_o(irq_msix_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic logic [39:0] pk(input logic [7:0] b0, b1, b2, b3, b4);
    return {b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [39:0] exp_get(input logic [4:0] en);
    logic [39:0] r = '0;
    for (int i = 0; i < 4; i++) if (en[i]) r[8*i +: 8] = {4'(2 + i), 4'h1};
    if (en[4]) r[39:32] = 8'h01;
    return r;
  endfunction

  // driver: push expected response, issue command, confirm done pulse width
  task automatic do_cmd(input logic op, input logic [3:0] len, input logic [39:0] pl);
    logic [1:0] s = 2'd0; logic [3:0] l; logic [39:0] p = '0;
    if (op == 1'b0) begin
      l = 4'd5; p = exp_get(model_en);
    end else if (len < 4) begin
      s = 2'd1; l = 4'd0;
    end else begin
      for (int i = 0; i < 4; i++) model_en[i] = (pl[8*i +: 2] == 2'b01);
      if (len >= 5) begin model_en[4] = (pl[33:32] == 2'b01); l = 4'd5; end
      else l = len;
    end
    rsp_q.push_back({s, l, p});
    step();
    cmd_valid_i = 1; cmd_op_i = op; cmd_len_i = len; cmd_payload_i = pl;
    step();
    cmd_valid_i = 0;
    step();
    chk(!rsp_done_o, "R10", "done pulse width", rsp_done_o, 0);
    chk(rsp_q.size() == 0, "R10", "response missing", rsp_q.size(), 0);
  endtask

  task automatic do_notify(input logic [4:0] ne, input logic mx, input logic ms);
    if (mx || ms)
      for (int i = 0; i < 5; i++)
        if (model_en[i] && ne[i]) irq_q.push_back({mx, (i == 4) ? 4'd2 : 4'(2 + i)});
    step();
    notify_i = 1; log_nonempty_i = ne; msix_en_i = mx; msi_en_i = ms;
    step();
    notify_i = 0;
  endtask

  task automatic drain(input string req);
    for (int n = 0; n < 40; n++) begin
      if (irq_q.size() == 0 && !irq_valid_o) break;
      step();
    end
    repeat (3) step();
    chk(irq_q.size() == 0 && !irq_valid_o, req, "notifications left", irq_q.size(), 0);
  endtask

  // monitors
  always @(negedge clk) begin
    if (rst_ni && rsp_done_o) begin
      if (rsp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        logic [45:0] e;
        e = rsp_q.pop_front();
        chk({rsp_status_o, rsp_len_o, rsp_payload_o} == e, "R3", "response",
            {rsp_status_o, rsp_len_o, rsp_payload_o}, e);
      end
    end
    if (rst_ni && irq_valid_o && irq_ready_i) begin
      if (irq_q.size() == 0) chk(0, "R8", "unexpected notification", {irq_msix_o, irq_vec_o}, 0);
      else begin
        logic [4:0] e;
        e = irq_q.pop_front();
        chk({irq_msix_o, irq_vec_o} == e, "R8", "notification {msix,vec}",
            {irq_msix_o, irq_vec_o}, e);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "all", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) step();
    chk(!irq_valid_o && !rsp_done_o, "R1", "outputs in reset", {irq_valid_o, rsp_done_o}, 0);
    rst_ni = 1;
    step();
    chk(!irq_valid_o && !rsp_done_o, "R1", "outputs after reset", {irq_valid_o, rsp_done_o}, 0);
    do_cmd(0, 0, '0);                                             // R1 all zero read
    // R3 R4 R7: enable every log
    do_cmd(1, 5, pk(8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
    do_cmd(0, 0, '0);
    chk(model_en == 5'h1f, "R3", "model all enabled", model_en, 5'h1f);
    // R2: modes 0,2,3 disable; upper bits ignored
    do_cmd(1, 5, pk(8'hF0, 8'h02, 8'h03, 8'hA1, 8'hFC));
    do_cmd(0, 0, '0);
    // R5: short write rejected, state kept
    do_cmd(1, 3, pk(8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
    do_cmd(1, 0, '0);
    do_cmd(0, 0, '0);
    // R6: length 4 keeps dynamic capacity enable
    do_cmd(1, 5, pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01));
    do_cmd(1, 4, pk(8'h00, 8'h01, 8'h00, 8'h00, 8'h00));
    do_cmd(0, 0, '0);
    do_cmd(1, 7, pk(8'h01, 8'h01, 8'h01, 8'h01, 8'h01));         // R6 long write -> len 5
    do_cmd(0, 0, '0);
    // R8 R7 R9: all logs, MSI-X preferred over MSI
    do_notify(5'h1f, 1, 1);
    drain("R8");
    // R9: MSI only
    do_notify(5'b01010, 0, 1);
    drain("R9");
    // R9: no path -> nothing
    do_notify(5'h1f, 0, 0);
    step();
    chk(!irq_valid_o, "R9", "no path sends nothing", irq_valid_o, 0);
    drain("R9");
    // disabled log stays silent
    do_cmd(1, 5, pk(8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    do_notify(5'h1f, 1, 0);
    drain("R8");
    // R11 and stall hold
    do_cmd(1, 5, pk(8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
    irq_ready_i = 0;
    do_notify(5'b00011, 1, 0);
    repeat (2) step();
    chk(irq_valid_o && irq_vec_o == 4'd2, "R8", "stalled vector held", irq_vec_o, 2);
    step();
    notify_i = 1; log_nonempty_i = 5'b11100;                     // ignored while pending
    step();
    notify_i = 0;
    step();
    chk(irq_valid_o && irq_vec_o == 4'd2 && irq_msix_o, "R11", "pending kept", irq_vec_o, 2);
    irq_ready_i = 1;
    drain("R11");
    summary();
  end
endmodule